// File: doc/BRIEF.md
# Decaying peak amplitude normalizer

This block scales a sampled signed reference signal so that its positive peak sits at full scale. It keeps a running positive peak that jumps up at once when a sample exceeds it and otherwise bleeds down geometrically by a fixed factor per accepted sample, much like a rectified peak hold with a discharge path. The reciprocal of that peak is the gain, and each sample is multiplied by it to give the normalized output.

Samples are signed Q1.15 values presented with a one-cycle strobe. The reciprocal comes from a bit-serial restoring divider, so each accepted sample takes a fixed number of cycles. The result then leaves as a saturated Q1.15 value with a one-cycle valid pulse. Strobes that arrive while a divide is running are dropped. A downstream phase detector can multiply the output with a locally generated sine.

Top module: `nrm_peak_normalizer`

## Requirements
- R1: After reset the stored peak equals PEAK_FLOOR (default 64), `norm_o` is 0 and `norm_vld_o` is 0.
- R2: When an accepted sample, read as signed, is greater than the stored peak, the stored peak becomes that sample.
- R3: Otherwise the stored peak becomes floor(peak * DECAY_Q16 / 65536), with DECAY_Q16 = 65208 (0.995). The result is raised to PEAK_FLOOR if it would fall below it.
- R4: The gain is floor(2^30 / peak), taken with the peak as updated by that same sample. It is computed by a restoring divider that produces one quotient bit per cycle.
- R5: `norm_o` equals (sample * gain) shifted right arithmetically by 15 bits, saturated to the range -32768 to 32767.
- R6: `norm_vld_o` is a single-cycle pulse. It is high in the cycle that follows the 32nd rising edge after the edge that accepted the sample.
- R7: A strobe seen while a divide is in progress is ignored. It produces no output pulse and leaves the stored peak unchanged.
- R8: A negative or zero sample never raises the stored peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 16 | Signed Q1.15 input sample |
| smp_vld_i | input | 1 | One-cycle strobe marking a new sample |
| norm_o | output | 16 | Signed Q1.15 normalized sample |
| norm_vld_o | output | 1 | One-cycle pulse when `norm_o` is updated |

## Verification
Each accepted sample has exactly one result. It becomes visible 32 rising edges after the accepting edge: 31 divider iterations plus one output register. The bench drives a strobe on a falling edge and counts falling edges until the valid pulse. It requires the pulse on the 33rd falling edge, which is the first one after the 32nd rising edge, and checks the value there. For a strobe dropped mid-divide, the bench confirms that the window brings only one pulse and that a later sample is scaled by the peak predicted without the dropped one.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    localparam int SMP_W     = 16;
    localparam int FRAC_W    = SMP_W - 1;
    localparam int PEAK_W    = SMP_W - 1;
    localparam int GAIN_W    = 2 * FRAC_W + 1;
    localparam int DECAY_SH  = 16;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1
    } div_state_e;

    typedef struct packed {
        logic [PEAK_W-1:0] rem;
        logic [GAIN_W-1:0] quo;
    } div_work_t;

    function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [SMP_W+GAIN_W:0] v);
        logic signed [SMP_W+GAIN_W:0] hi;
        logic signed [SMP_W+GAIN_W:0] lo;
        hi = (SMP_W+GAIN_W+1)'(2**(SMP_W-1) - 1);
        lo = -(SMP_W+GAIN_W+1)'(2**(SMP_W-1));
        if (v > hi)      return SMP_W'(hi);
        else if (v < lo) return SMP_W'(lo);
        else             return v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/nrm_peak_track.sv
module nrm_peak_track
    import nrm_pkg::*;
#(
    parameter int DECAY_Q16  = 65208,
    parameter int PEAK_FLOOR = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  logic signed [SMP_W-1:0] smp,
    output logic [PEAK_W-1:0]       peak_q,
    output logic [PEAK_W-1:0]       peak_d
);
    localparam logic [PEAK_W-1:0] FLOOR_V = PEAK_W'(PEAK_FLOOR);

    logic              rises;
    logic [PEAK_W-1:0] bled;

    always_comb begin
        rises = smp > $signed({1'b0, peak_q});
        bled  = PEAK_W'((32'(peak_q) * 32'(DECAY_Q16)) >> DECAY_SH);
        if (rises)              peak_d = smp[PEAK_W-1:0];
        else if (bled < FLOOR_V) peak_d = FLOOR_V;
        else                    peak_d = bled;
    end

    always_ff @(posedge clk) begin
        if (rst)         peak_q <= FLOOR_V;
        else if (accept) peak_q <= peak_d;
    end

    p_peak_floor_r3: assert property (@(posedge clk) disable iff (rst)
        peak_q >= FLOOR_V);
    p_peak_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && smp > $signed({1'b0, peak_q})) |=> (peak_q == $past(smp[PEAK_W-1:0])));
    p_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && smp <= $signed({1'b0, peak_q})) |=> (peak_q <= $past(peak_q)));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(peak_q));
endmodule

// File: rtl/nrm_recip_div.sv
module nrm_recip_div
    import nrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PEAK_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic [GAIN_W-1:0] gain
);
    localparam int CNT_W = $clog2(GAIN_W + 1);
    localparam logic [GAIN_W-1:0] DIVIDEND = GAIN_W'(1) << (GAIN_W - 1);

    div_state_e         st;
    div_work_t          wk;
    logic [PEAK_W-1:0]  dv_q;
    logic [CNT_W-1:0]   cnt;
    logic [PEAK_W:0]    shifted;
    logic [PEAK_W+1:0]  trial;

    always_comb begin
        shifted = {wk.rem, wk.quo[GAIN_W-1]};
        trial   = {1'b0, shifted} - {2'b00, dv_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= DV_IDLE;
            wk   <= '0;
            dv_q <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                DV_IDLE: if (start) begin
                    wk.rem <= '0;
                    wk.quo <= DIVIDEND;
                    dv_q   <= divisor;
                    cnt    <= '0;
                    st     <= DV_RUN;
                end
                default: begin
                    if (!trial[PEAK_W+1]) begin
                        wk.rem <= trial[PEAK_W-1:0];
                        wk.quo <= {wk.quo[GAIN_W-2:0], 1'b1};
                    end else begin
                        wk.rem <= shifted[PEAK_W-1:0];
                        wk.quo <= {wk.quo[GAIN_W-2:0], 1'b0};
                    end
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(GAIN_W - 1)) begin
                        st   <= DV_IDLE;
                        done <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (st == DV_RUN);
    assign gain = wk.quo;

    p_quotient_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ((64'(gain) * 64'(dv_q) <= 64'(DIVIDEND)) &&
                  (64'(gain) * 64'(dv_q) + 64'(dv_q) > 64'(DIVIDEND))));
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

// File: rtl/nrm_scale_sat.sv
module nrm_scale_sat
    import nrm_pkg::*;
(
    input  logic signed [SMP_W-1:0] smp,
    input  logic [GAIN_W-1:0]       gain,
    output logic signed [SMP_W-1:0] scaled
);
    logic signed [SMP_W+GAIN_W:0] prod;
    logic signed [SMP_W+GAIN_W:0] shr;

    always_comb begin
        prod   = (SMP_W+GAIN_W+1)'(smp) * $signed({1'b0, gain});
        shr    = prod >>> FRAC_W;
        scaled = sat_smp(shr);
    end
endmodule

// File: rtl/nrm_peak_normalizer.sv
module nrm_peak_normalizer
    import nrm_pkg::*;
#(
    parameter int DECAY_Q16  = 65208,
    parameter int PEAK_FLOOR = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic                    smp_vld_i,
    output logic signed [SMP_W-1:0] norm_o,
    output logic                    norm_vld_o
);
    logic                    accept;
    logic                    div_busy;
    logic                    div_done;
    logic [PEAK_W-1:0]       peak_q;
    logic [PEAK_W-1:0]       peak_d;
    logic [GAIN_W-1:0]       gain;
    logic signed [SMP_W-1:0] smp_q;
    logic signed [SMP_W-1:0] scaled;

    assign accept = smp_vld_i && !div_busy;

    nrm_peak_track #(.DECAY_Q16(DECAY_Q16), .PEAK_FLOOR(PEAK_FLOOR)) u_peak (
        .clk(clk), .rst(rst), .accept(accept), .smp(smp_i),
        .peak_q(peak_q), .peak_d(peak_d)
    );

    nrm_recip_div u_div (
        .clk(clk), .rst(rst), .start(accept), .divisor(peak_d),
        .busy(div_busy), .done(div_done), .gain(gain)
    );

    nrm_scale_sat u_scale (.smp(smp_q), .gain(gain), .scaled(scaled));

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q      <= '0;
            norm_o     <= '0;
            norm_vld_o <= 1'b0;
        end else begin
            if (accept) smp_q <= smp_i;
            norm_vld_o <= div_done;
            if (div_done) norm_o <= scaled;
        end
    end

    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        norm_vld_o |=> !norm_vld_o);
    p_out_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(div_done) |-> $stable(norm_o));
    p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && div_busy) |=> $stable(peak_q));
endmodule

// File: tb/nrm_peak_normalizer_tb.sv
module nrm_peak_normalizer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] smp_i = '0;
    logic smp_vld_i = 1'b0;
    logic signed [15:0] norm_o;
    logic norm_vld_o;

    int total = 0;
    int bad = 0;
    int peak_m = 64;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nrm_peak_normalizer u_dut (
        .clk(clk), .rst(rst), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
        .norm_o(norm_o), .norm_vld_o(norm_vld_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input int s);
        longint g;
        longint p;
        if (s > peak_m) peak_m = s;
        else begin
            peak_m = (peak_m * 65208) >>> 16;
            if (peak_m < 64) peak_m = 64;
        end
        g = (longint'(1) <<< 30) / peak_m;
        p = (longint'(s) * g) >>> 15;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return p;
    endfunction

    // drive one sample, check value and latency; optional intruder strobe mid-divide
    task automatic send(input int s, input string req, input bit intrude, input bit quiet);
        longint e;
        int k;
        int pulses;
        e = model(s);
        @(negedge clk);
        smp_i = 16'(s);
        smp_vld_i = 1'b1;
        k = 0;
        pulses = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            k++;
            smp_vld_i = (intrude && k == 5);
            if (intrude && k == 5) smp_i = 16'sd30000;
            if (norm_vld_o) begin
                pulses++;
                if (pulses == 1) begin
                    if (!quiet) begin
                        chk({req, " latency"}, k, 33);
                        chk({req, " value"}, norm_o, e);
                    end else if (k != 33 || norm_o != 16'(e)) begin
                        chk({req, " value"}, norm_o, e);
                    end
                end
            end
        end
        if (intrude) chk("R7 single pulse", pulses, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 vld", norm_vld_o, 0);
        chk("R1 out", norm_o, 0);
        // peak at floor 64: sample 32 -> gain 2^24 -> 16384
        send(32, "R1 floor", 0, 0);
    endtask

    task automatic t_rise();
        send(16000, "R2 rise", 0, 0);
        send(20000, "R2 rise again", 0, 0);
    endtask

    task automatic t_decay();
        send(1000, "R3 decay", 0, 0);
        send(1000, "R3 decay2", 0, 0);
        send(0, "R3 zero", 0, 0);
    endtask

    task automatic t_negative();
        send(-15000, "R8 negative", 0, 0);
        send(5000, "R8 after negative", 0, 0);
    endtask

    task automatic t_saturate();
        send(25000, "R5 at peak", 0, 0);
        send(-32768, "R5 neg sat", 0, 0);
        send(24000, "R4 gain", 0, 0);
    endtask

    task automatic t_busy();
        send(3000, "R7 host", 1, 0);
        send(3000, "R7 peak untouched", 0, 0);
    endtask

    task automatic t_floor();
        send(200, "R3 set small", 0, 0);
        for (int i = 0; i < 300; i++) send(0, "R3 bleed", 0, 1);
        send(1, "R3 floor held", 0, 0);
        send(-1, "R5 tiny neg", 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rise();
        t_decay();
        t_negative();
        t_saturate();
        t_busy();
        t_floor();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule